// File: doc/BRIEF.md
# Broadcast Output-Stationary Matrix Multiplier

This block computes the product C = A × B for square or rectangular matrices that fit in an N×N grid. Every output element has its own accumulator register, so the whole grid updates in one clock. Each clock performs one reduction step k. On that step, row bank i of the A memory supplies A[i][k] to every accumulator in grid row i. Column bank j of the B memory supplies B[k][j] to every accumulator in grid column j. Operands are never handed from one processing element to the next. Runtime row and column counts let a smaller problem run on the same grid. Operands outside those counts are forced to zero before they are multiplied.

A single-cycle start pulse latches the four dimension inputs and begins the fetch/accumulate phase. The block issues one read step index per cycle and expects the memory banks to return data on the following cycle. After the last accumulation, the block writes the result out one grid row per cycle, for N cycles. It then pulses done.

Top module: `mm_bcast`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, rdEn and wrEn are all low.
- R2: The cycle after start is sampled high in idle, busy is high. For the next S cycles, rdEn is high with rdK = 0, 1, …, S−1. S is aCols, limited to the range 1..N. The banks must return A[i][rdK] on aBankData bits [i*32 +: 32] and B[rdK][j] on bBankData bits [j*32 +: 32] one cycle after rdEn.
- R3: Each result element equals the sum over k of A[i][k]·B[k][j], for the steps k < aCols, in 32-bit wrap-around arithmetic.
- R4: A values are treated as zero when i ≥ aRows or k ≥ aCols. The values held in the memory at those places have no effect on wrData.
- R5: B values are treated as zero when k ≥ bRows or j ≥ bCols.
- R6: aCols = 0 runs one step and yields an all-zero result. aCols > N runs N steps.
- R7: wrEn is high for exactly N consecutive cycles. The first of these comes S+1 cycles after busy first rises. wrRow counts 0 to N−1, and wrData holds row wrRow, with column j at bits [j*32 +: 32].
- R8: done is high for one cycle, in the cycle after the last writeback. busy is low in that same cycle.
- R9: A start pulse while busy is ignored. It changes neither the timing nor the results of the running job.
- R10: Each job starts from a fresh sum, so results never carry over from a previous job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse, accepted in idle |
| aRows | input | 3 | Valid rows of A |
| aCols | input | 3 | Valid columns of A (reduction length) |
| bRows | input | 3 | Valid rows of B |
| bCols | input | 3 | Valid columns of B |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| rdEn | output | 1 | Memory read strobe |
| rdK | output | 2 | Reduction step index to read |
| aBankData | input | 128 | A row banks, one word per bank |
| bBankData | input | 128 | B column banks, one word per bank |
| wrEn | output | 1 | Result row valid |
| wrRow | output | 2 | Result row index |
| wrData | output | 128 | Result row, one word per column |

## Verification
A corrupted accumulator stays hidden until writeback. At writeback it shows as a wrong word in exactly one row and column of wrData, S+1 to S+N cycles after the job started. A wrong step counter shows sooner, through a misplaced rdK or a shifted wrEn window. A wrong gating decision affects a whole row or column. The bench fills the out-of-range memory cells with nonzero values so that such a fault shows up at the ports.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_DRAIN} mm_state_t;

  typedef struct packed {
    logic accEn;
    logic firstStep;
    logic wrEn;
  } mm_strobe_t;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl import mm_pkg::*; #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1),
  parameter int KW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] aRows,
  input  logic [CW-1:0] aCols,
  input  logic [CW-1:0] bRows,
  input  logic [CW-1:0] bCols,
  output logic          busy,
  output logic          done,
  output logic          rdEn,
  output logic [KW-1:0] rdK,
  output mm_strobe_t    strb,
  output logic [KW-1:0] accK,
  output logic [KW-1:0] wrRow,
  output logic [CW-1:0] aRowsQ,
  output logic [CW-1:0] aColsQ,
  output logic [CW-1:0] bRowsQ,
  output logic [CW-1:0] bColsQ
);
  localparam logic [CW-1:0] NMAX = CW'(N);

  mm_state_t     state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stepsQ;
  logic [CW-1:0] stepsD;
  logic [KW-1:0] row;

  // a zero-length reduction still runs one step; gating makes it zero
  always_comb begin
    if (aCols == '0)       stepsD = CW'(1);
    else if (aCols > NMAX) stepsD = NMAX;
    else                   stepsD = aCols;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      stepsQ <= '0;
      row    <= '0;
      done   <= 1'b0;
      aRowsQ <= '0;
      aColsQ <= '0;
      bRowsQ <= '0;
      bColsQ <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            aRowsQ <= aRows;
            aColsQ <= aCols;
            bRowsQ <= bRows;
            bColsQ <= bCols;
            stepsQ <= stepsD;
            cnt    <= '0;
            state  <= S_CALC;
          end
        end
        S_CALC: begin
          cnt <= cnt + CW'(1);
          if (cnt == stepsQ) begin
            row   <= '0;
            state <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          row <= row + KW'(1);
          if (row == KW'(N - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy           = (state != S_IDLE);
    rdEn           = (state == S_CALC) && (cnt < stepsQ);
    rdK            = cnt[KW-1:0];
    accK           = KW'(cnt - CW'(1));
    strb.accEn     = (state == S_CALC) && (cnt != '0);
    strb.firstStep = (cnt == CW'(1));
    strb.wrEn      = (state == S_DRAIN);
    wrRow          = row;
  end
endmodule

// File: rtl/mm_cell.sv
module mm_cell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          accEn,
  input  logic          firstStep,
  input  logic [DW-1:0] aVal,
  input  logic [DW-1:0] bVal,
  output logic [DW-1:0] acc
);
  logic [DW-1:0] prod;
  logic [DW-1:0] base;

  assign prod = aVal * bVal;
  assign base = firstStep ? '0 : acc;

  always_ff @(posedge clk) begin
    if (!rstN)      acc <= '0;
    else if (accEn) acc <= base + prod;
  end
endmodule

// File: rtl/mm_grid.sv
module mm_grid import mm_pkg::*; #(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int CW = $clog2(N + 1),
  parameter int KW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rstN,
  input  mm_strobe_t      strb,
  input  logic [KW-1:0]   accK,
  input  logic [KW-1:0]   wrRow,
  input  logic [CW-1:0]   aRowsQ,
  input  logic [CW-1:0]   aColsQ,
  input  logic [CW-1:0]   bRowsQ,
  input  logic [CW-1:0]   bColsQ,
  input  logic [N*DW-1:0] aBankData,
  input  logic [N*DW-1:0] bBankData,
  output logic [N*DW-1:0] wrData
);
  logic [DW-1:0] aLine [N];
  logic [DW-1:0] bLine [N];
  logic [DW-1:0] accQ  [N][N];
  logic [CW-1:0] kExt;

  assign kExt = CW'(accK);

  for (genvar i = 0; i < N; i++) begin : g_line
    assign aLine[i] = (CW'(i) < aRowsQ && kExt < aColsQ) ? aBankData[i*DW +: DW] : '0;
    assign bLine[i] = (kExt < bRowsQ && CW'(i) < bColsQ) ? bBankData[i*DW +: DW] : '0;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      mm_cell #(.DW(DW)) u_cell (
        .clk       (clk),
        .rstN      (rstN),
        .accEn     (strb.accEn),
        .firstStep (strb.firstStep),
        .aVal      (aLine[r]),
        .bVal      (bLine[c]),
        .acc       (accQ[r][c])
      );
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++) wrData[c*DW +: DW] = accQ[wrRow][c];
  end
endmodule

// File: rtl/mm_bcast.sv
module mm_bcast import mm_pkg::*; #(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int CW = $clog2(N + 1),
  parameter int KW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CW-1:0]   aRows,
  input  logic [CW-1:0]   aCols,
  input  logic [CW-1:0]   bRows,
  input  logic [CW-1:0]   bCols,
  output logic            busy,
  output logic            done,
  output logic            rdEn,
  output logic [KW-1:0]   rdK,
  input  logic [N*DW-1:0] aBankData,
  input  logic [N*DW-1:0] bBankData,
  output logic            wrEn,
  output logic [KW-1:0]   wrRow,
  output logic [N*DW-1:0] wrData
);
  mm_strobe_t    strb;
  logic [KW-1:0] accK;
  logic [CW-1:0] aRowsQ, aColsQ, bRowsQ, bColsQ;

  mm_ctrl #(.N(N), .CW(CW), .KW(KW)) u_ctrl (
    .clk, .rstN, .start, .aRows, .aCols, .bRows, .bCols,
    .busy, .done, .rdEn, .rdK, .strb, .accK, .wrRow,
    .aRowsQ, .aColsQ, .bRowsQ, .bColsQ
  );

  mm_grid #(.N(N), .DW(DW), .CW(CW), .KW(KW)) u_grid (
    .clk, .rstN, .strb, .accK, .wrRow,
    .aRowsQ, .aColsQ, .bRowsQ, .bColsQ,
    .aBankData, .bBankData, .wrData
  );

  assign wrEn = strb.wrEn;
endmodule

// File: rtl/mm_bcast_chk.sv
module mm_bcast_chk #(
  parameter int KW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rdEn,
  input logic          wrEn,
  input logic [KW-1:0] wrRow
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrEn) |-> done);
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  a_r2_read_in_job: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> busy && !wrEn);
  a_r7_write_in_job: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);
  a_r7_row_order: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> wrRow == $past(wrRow) + KW'(1));
  a_r7_first_row: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrEn) |-> wrRow == '0);
endmodule

bind mm_bcast mm_bcast_chk #(.KW(KW)) u_chk (
  .clk, .rstN, .start, .busy, .done, .rdEn, .wrEn, .wrRow
);

// File: tb/mm_bcast_test.sv
module mm_bcast_test;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int CW = $clog2(N + 1);
  localparam int KW = $clog2(N);
  localparam int NV = 8;
  // aRows, aCols, bRows, bCols, seed
  localparam int VEC [NV][5] = '{
    '{4, 4, 4, 4, 1},
    '{2, 3, 3, 4, 2},
    '{4, 2, 1, 3, 3},
    '{1, 1, 1, 1, 4},
    '{3, 4, 4, 2, 5},
    '{4, 0, 4, 4, 6},
    '{4, 6, 7, 4, 7},
    '{0, 4, 4, 4, 8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] aRows = '0, aCols = '0, bRows = '0, bCols = '0;
  logic busy, done, rdEn, wrEn;
  logic [KW-1:0] rdK, wrRow;
  logic [N*DW-1:0] aBankData = '0, bBankData = '0, wrData;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] memA [N][N];
  logic [DW-1:0] memB [N][N];
  logic [DW-1:0] expC [N][N];

  always #2.5 clk = ~clk;

  mm_bcast uut (
    .clk, .rstN, .start, .aRows, .aCols, .bRows, .bCols,
    .busy, .done, .rdEn, .rdK, .aBankData, .bBankData,
    .wrEn, .wrRow, .wrData
  );

  // banked memories with one cycle of read latency
  always @(posedge clk) begin
    if (rdEn) begin
      for (int b = 0; b < N; b++) begin
        aBankData[b*DW +: DW] <= memA[b][rdK];
        bBankData[b*DW +: DW] <= memB[rdK][b];
      end
    end
  end

  task automatic fill(input int seed);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        memA[r][c] = DW'(seed * 32'h01234567 + r * 977 - c * 31 + 5);
        memB[r][c] = DW'(seed * 32'h00ABCDEF - r * 613 + c * 89 + 3);
      end
  endtask

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic runJob(input int aR, input int aC, input int bR, input int bC, input bit midStart);
    int steps;
    int rdBad = 0, wrBad = 0, doneBad = 0;
    logic [DW-1:0] av, bv;
    steps = (aC == 0) ? 1 : ((aC > N) ? N : aC);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        expC[i][j] = '0;
        for (int k = 0; k < steps; k++) begin
          av = (i < aR && k < aC) ? memA[i][k] : '0;
          bv = (k < bR && j < bC) ? memB[k][j] : '0;
          expC[i][j] = expC[i][j] + av * bv;
        end
      end
    @(negedge clk);
    aRows = CW'(aR); aCols = CW'(aC); bRows = CW'(bR); bCols = CW'(bC);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
    for (int cyc = 1; cyc <= steps + 2 + N; cyc++) begin
      bit expRd, expWr, expDone;
      if (midStart && cyc == 3) begin
        aRows = CW'(1); aCols = CW'(1); start = 1'b1;  // R9 ignored start
      end else start = 1'b0;
      expRd = (cyc <= steps);
      if (rdEn !== expRd || (expRd && rdK !== KW'(cyc - 1))) rdBad++;
      expWr = (cyc >= steps + 2) && (cyc <= steps + 1 + N);
      if (wrEn !== expWr) wrBad++;
      if (expWr) begin
        int r = cyc - steps - 2;
        if (wrRow !== KW'(r)) wrBad++;
        for (int j = 0; j < N; j++)
          check(wrData[j*DW +: DW] === expC[r][j],
                $sformatf("R3/R4/R5 row %0d col %0d", r, j),
                longint'(wrData[j*DW +: DW]), longint'(expC[r][j]));
      end
      expDone = (cyc == steps + 2 + N);
      if (done !== expDone || busy !== !expDone) doneBad++;
      @(negedge clk);
    end
    start = 1'b0;
    check(rdBad == 0, "R2 read sequence mismatches", rdBad, 0);
    check(wrBad == 0, "R7 writeback window and rows mismatches", wrBad, 0);
    check(doneBad == 0, "R8 done and busy mismatches", doneBad, 0);
  endtask

  initial begin
    #(5 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && rdEn === 1'b0 && wrEn === 1'b0,
          "R1 outputs low in reset", {busy, done, rdEn, wrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && rdEn === 1'b0 && wrEn === 1'b0,
          "R1 outputs low after reset", {busy, done, rdEn, wrEn}, 0);

    // table walk: R3 full, R4/R5 partial shapes, R6 aCols 0 and clamp
    for (int v = 0; v < NV; v++) begin
      fill(VEC[v][4]);
      runJob(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
    end

    // R9: start pulsed mid-job with other dims has no effect
    fill(11);
    runJob(3, 4, 4, 3, 1'b1);

    // R10: small job after a large one starts from zero
    fill(12);
    runJob(4, 4, 4, 4, 1'b0);
    runJob(2, 1, 1, 2, 1'b0);

    // R6: aCols zero again after a nonzero job
    runJob(4, 0, 4, 4, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule